// File: doc/BRIEF.md
# Oversampled serial receiver with two-stage buffering and error flags

This block receives asynchronous serial frames on a single line. The line is sampled 16 times per bit, and the sample rate comes from a tick strobe supplied from outside. A start bit is confirmed at its middle. The data bits are then collected, least significant first, into a shift stage. At a point that depends on the frame format, the finished word moves into a holding stage, and the host reads the word from there.

The receiver supports seven, eight and nine bit frames. In the seven and eight bit formats, a parity bit can be added. Three sticky error indications are kept:
- Overrun: a new word arrives while the held word is still unread.
- Parity: the parity bit does not match the held data.
- Framing: the stop bit is bad by a majority of three samples.

A one-cycle receive interrupt marks each completed frame. In the formats that carry nine bits after the start bit, the interrupt is raised at the middle of the ninth bit. The stop bit is judged later, so in those formats a framing error becomes visible after the interrupt.

The configuration inputs must not change while a frame is in progress.

Top module: `uart_rx_dualbuf`

## Requirements
- R1: After reset all outputs are 0: `data_o`, `valid_o`, `irq_o` and the three error flags.
- R2: The line passes through a two-flop synchronizer. A low level that is no longer low at the middle of the start bit, 8 ticks after it is detected, is discarded. It produces no interrupt, no word and no flag, and the receiver returns to waiting for a start bit.
- R3: `fmt_i` selects the frame: 0 gives 7 data bits, 1 gives 8 data bits, and 2 or 3 give 9 bits. Bits arrive least significant first, one bit per 16 ticks. Bit k of the frame lands in `data_o[k]`, and bits beyond the frame length read as 0.
- R4: With `par_en_i`=1 in format 0 or 1, one parity bit follows the data bits and is held in `data_o[7]` (format 0) or `data_o[8]` (format 1). The parity expected is the XOR of the data bits, inverted when `par_odd_i`=1. A mismatch, computed from the held word, sets `par_err_o`. In format 2 or 3, `par_en_i` has no effect.
- R5: `irq_o` is a one-cycle pulse for every completed frame. When the frame carries 9 bits after the start bit (format 2/3, or format 1 with parity), the pulse occurs at the middle of the last bit. Otherwise it occurs at the middle of the stop bit. With a tick on every clock, and the start edge driven just before clock edge 1, the pulse is visible after edge 27+16·8 = 155 for 9-bit frames, and after edge 27+16·n for frames of n bits.
- R6: The stop bit is sampled on the three ticks up to and including its middle. If at least two of those samples are 0, `frm_err_o` is set at the middle of the stop bit. In 9-bit frames this happens 16 ticks after the interrupt.
- R7: If a frame completes while `valid_o`=1 and no read occurs in that cycle, `ovr_err_o` is set, the held word is kept and the new word is dropped.
- R8: A frame that is not an overrun loads the holding stage and sets `valid_o` in the same cycle as its interrupt. `rd_i` clears `valid_o`. A load in the same cycle wins.
- R9: The error flags stay set until `clr_err_i`. A flag that is set in the same cycle as a clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling strobe, 16 per bit |
| fmt_i | input | 2 | Frame format: 0 = 7 bits, 1 = 8 bits, 2/3 = 9 bits |
| par_en_i | input | 1 | Append parity in formats 0 and 1 |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| rd_i | input | 1 | Host read strobe, clears `valid_o` |
| clr_err_i | input | 1 | Clears all three error flags |
| data_o | output | 9 | Held word |
| valid_o | output | 1 | Held word not yet read |
| ovr_err_o | output | 1 | Sticky overrun flag |
| par_err_o | output | 1 | Sticky parity flag |
| frm_err_o | output | 1 | Sticky framing flag |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
The bench ticks on every clock and changes the line at falling edges. Each frame is counted in cycles from the falling edge that drives the start bit.

The interrupt pulse must first appear at cycle 155 for 9-bit and 8-bit frames, and at cycle 139 for bare 7-bit frames. The bench samples on every falling edge and records the first cycle it sees the pulse, so a pulse one edge early or late is a miscompare.

For 9-bit frames with a bad stop bit, the framing flag is sampled in the interrupt cycle, where it must be 0. It is sampled again after the stop-bit middle at cycle 171, where it must be 1.

The held word, the valid flag and the parity and overrun flags are read after the line has been idle for eight cycles. By then every register that feeds them has settled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned WORD_W = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  // bits carried after the start bit, before the stop bit
  function automatic logic [3:0] frame_bits(input logic [1:0] fmt, input logic par_en);
    case (fmt)
      2'd0:    frame_bits = 4'd7 + {3'd0, par_en};
      2'd1:    frame_bits = 4'd8 + {3'd0, par_en};
      default: frame_bits = 4'd9;
    endcase
  endfunction

  // 1 when the held word's parity bit disagrees with its data
  function automatic logic parity_bad(input logic [WORD_W-1:0] w, input logic [1:0] fmt,
                                      input logic par_en, input logic odd);
    logic exp;
    parity_bad = 1'b0;
    if (par_en && fmt == 2'd0) begin
      exp = (^w[6:0]) ^ odd;
      parity_bad = exp != w[7];
    end else if (par_en && fmt == 2'd1) begin
      exp = (^w[7:0]) ^ odd;
      parity_bad = exp != w[8];
    end
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [3:0]        nbits_i,
  output logic              xfer_o,
  output logic [WORD_W-1:0] word_o,
  output logic              stop_o,
  output logic              frm_bad_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] C_HALF = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] C_S0   = CW'(OVS - 3);
  localparam logic [CW-1:0] C_S1   = CW'(OVS - 2);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [3:0]        bidx_q;
  logic [WORD_W-1:0] sh_q, sh_nxt;
  logic              smp0_q, smp1_q;
  logic              at_mid, last_bit, full;

  assign at_mid   = tick_i && cnt_q == C_LAST;
  assign last_bit = (bidx_q + 4'd1) == nbits_i;
  assign full     = nbits_i == 4'(WORD_W);

  always_comb begin
    sh_nxt = sh_q;
    for (int i = 0; i < WORD_W; i++)
      if (4'(i) == bidx_q) sh_nxt[i] = rx_i;
  end

  // majority of three stop samples; the third is the mid-bit one
  assign frm_bad_o = !((smp0_q & smp1_q) | (smp0_q & rx_i) | (smp1_q & rx_i));
  assign stop_o    = state_q == ST_STOP && at_mid;
  assign xfer_o    = (state_q == ST_DATA && at_mid && last_bit && full) ||
                     (stop_o && !full);
  assign word_o    = (state_q == ST_DATA) ? sh_nxt : sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      smp0_q  <= 1'b1;
      smp1_q  <= 1'b1;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: if (!rx_i) begin
          state_q <= ST_START;
          cnt_q   <= '0;
          bidx_q  <= '0;
          sh_q    <= '0;
        end
        ST_START: begin
          if (cnt_q == C_HALF) begin
            state_q <= rx_i ? ST_IDLE : ST_DATA;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: begin
          if (cnt_q == C_LAST) begin
            cnt_q  <= '0;
            sh_q   <= sh_nxt;
            bidx_q <= bidx_q + 4'd1;
            if (last_bit) state_q <= ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_STOP: begin
          if (cnt_q == C_S0) smp0_q <= rx_i;
          if (cnt_q == C_S1) smp1_q <= rx_i;
          if (cnt_q == C_LAST) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              stop_i,
  input  logic              frm_bad_i,
  input  logic [1:0]        fmt_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rd_i,
  input  logic              clr_err_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              ovr_err_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              irq_o
);
  logic overrun, load;

  assign overrun = xfer_i && valid_o && !rd_i;
  assign load    = xfer_i && !overrun;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      valid_o   <= 1'b0;
      ovr_err_o <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= xfer_i;
      if (load) begin
        data_o  <= word_i;
        valid_o <= 1'b1;
      end else if (rd_i) valid_o <= 1'b0;
      // set has priority over clear
      ovr_err_o <= overrun | (ovr_err_o & !clr_err_i);
      par_err_o <= (load && parity_bad(word_i, fmt_i, par_en_i, par_odd_i)) |
                   (par_err_o & !clr_err_i);
      frm_err_o <= (stop_i && frm_bad_i) | (frm_err_o & !clr_err_i);
    end
  end
endmodule

// File: rtl/uart_rx_dualbuf.sv
module uart_rx_dualbuf
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic [1:0]        fmt_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rd_i,
  input  logic              clr_err_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              ovr_err_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              irq_o
);
  logic              rx_s;
  logic              xfer, stop, frm_bad;
  logic [WORD_W-1:0] word;
  logic [3:0]        nbits;

  assign nbits = frame_bits(fmt_i, par_en_i);

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .rx_i     (rx_s),
    .nbits_i  (nbits),
    .xfer_o   (xfer),
    .word_o   (word),
    .stop_o   (stop),
    .frm_bad_o(frm_bad)
  );

  uart_rx_hold u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xfer_i   (xfer),
    .word_i   (word),
    .stop_i   (stop),
    .frm_bad_i(frm_bad),
    .fmt_i    (fmt_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .rd_i     (rd_i),
    .clr_err_i(clr_err_i),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .ovr_err_o(ovr_err_o),
    .par_err_o(par_err_o),
    .frm_err_o(frm_err_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/uart_rx_dualbuf_chk.sv
module uart_rx_dualbuf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic       clr_err_i,
  input logic [8:0] data_o,
  input logic       valid_o,
  input logic       ovr_err_o,
  input logic       par_err_o,
  input logic       frm_err_o,
  input logic       irq_o
);
  a_r5_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r7_word_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !rd_i |=> $stable(data_o));

  a_r7_ovr_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_err_o) |-> $past(valid_o));

  a_r8_valid_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> irq_o);

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (!valid_o || irq_o));

  a_r9_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_err_o && !clr_err_i |=> ovr_err_o);

  a_r9_par_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o && !clr_err_i |=> par_err_o);

  a_r9_frm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_o && !clr_err_i |=> frm_err_o);
endmodule

bind uart_rx_dualbuf uart_rx_dualbuf_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .clr_err_i(clr_err_i),
  .data_o   (data_o),
  .valid_o  (valid_o),
  .ovr_err_o(ovr_err_o),
  .par_err_o(par_err_o),
  .frm_err_o(frm_err_o),
  .irq_o    (irq_o)
);

// File: tb/sim_uart_rx_dualbuf.sv
`timescale 1ns/1ps
module sim_uart_rx_dualbuf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1, tick = 1'b1, par_en = 1'b0, par_odd = 1'b0, rd = 1'b0, clr = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [8:0] data;
  logic       valid, ovr, perr, ferr, irq;
  int         n_chk = 0, n_bad = 0;
  int         irq_at, frm_at_irq;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  uart_rx_dualbuf u0 (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick_i(tick), .fmt_i(fmt),
    .par_en_i(par_en), .par_odd_i(par_odd), .rd_i(rd), .clr_err_i(clr),
    .data_o(data), .valid_o(valid), .ovr_err_o(ovr), .par_err_o(perr),
    .frm_err_o(ferr), .irq_o(irq)
  );

  typedef struct packed {
    logic [1:0] fmt;
    logic       pe;
    logic       odd;
    logic [8:0] raw;
    logic       stop;
    logic       perr;
    logic       ferr;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'd0, 1'b0, 1'b0, 9'h055, 1'b1, 1'b0, 1'b0},  // R3 7-bit
    '{2'd0, 1'b1, 1'b0, 9'h093, 1'b1, 1'b0, 1'b0},  // R4 7+even, good
    '{2'd0, 1'b1, 1'b0, 9'h013, 1'b1, 1'b1, 1'b0},  // R4 7+even, bad
    '{2'd1, 1'b0, 1'b0, 9'h0A5, 1'b1, 1'b0, 1'b0},  // R3 8-bit
    '{2'd1, 1'b1, 1'b1, 9'h10F, 1'b1, 1'b0, 1'b0},  // R4 8+odd, good
    '{2'd1, 1'b1, 1'b1, 9'h00F, 1'b1, 1'b1, 1'b0},  // R4 8+odd, bad
    '{2'd2, 1'b0, 1'b0, 9'h1C3, 1'b1, 1'b0, 1'b0},  // R3 9-bit
    '{2'd1, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b0, 1'b1},  // R6 8-bit bad stop
    '{2'd2, 1'b1, 1'b0, 9'h1FF, 1'b1, 1'b0, 1'b0}   // R4 parity ignored in 9-bit
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] f, input logic pe);
    if (f == 2'd0) return 7 + int'(pe);
    if (f == 2'd1) return 8 + int'(pe);
    return 9;
  endfunction

  task automatic pulse_rd_clr(input bit do_rd, input bit do_clr);
    @(negedge clk);
    rd = do_rd; clr = do_clr;
    @(negedge clk);
    rd = 1'b0; clr = 1'b0;
  endtask

  // start edge driven at cycle 0; irq_at holds the first negedge index with irq high
  task automatic send(input logic [8:0] raw, input int n, input logic stop);
    int cyc = 0;
    irq_at = 0; frm_at_irq = 0;
    for (int b = 0; b < n + 3; b++) begin
      if (b == 0) rxd = 1'b0;
      else if (b <= n) rxd = raw[b-1];
      else if (b == n + 1) rxd = stop;
      else rxd = 1'b1;
      for (int t = 0; t < ((b == n + 2) ? 8 : 16); t++) begin
        @(negedge clk);
        cyc++;
        if (irq && irq_at == 0) begin
          irq_at = cyc;
          frm_at_irq = int'(ferr);
        end
      end
    end
    rxd = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 data", int'(data), 0);
    check("R1 flags", int'({valid, ovr, perr, ferr, irq}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    foreach (VEC[i]) begin
      int n, exp_irq;
      n = nbits_of(VEC[i].fmt, VEC[i].pe);
      exp_irq = (n == 9) ? 27 + 16 * 8 : 27 + 16 * n;
      fmt = VEC[i].fmt; par_en = VEC[i].pe; par_odd = VEC[i].odd;
      pulse_rd_clr(1'b1, 1'b1);
      send(VEC[i].raw, n, VEC[i].stop);
      check("R5 irq cycle", irq_at, exp_irq);
      check("R3 word", int'(data), int'(VEC[i].raw & 9'((1 << n) - 1)));
      check("R8 valid", int'(valid), 1);
      check("R4 parity flag", int'(perr), int'(VEC[i].perr));
      check("R6 framing flag", int'(ferr), int'(VEC[i].ferr));
      check("R7 no overrun", int'(ovr), 0);
    end

    // R6: 9-bit frame, framing error appears after the interrupt
    fmt = 2'd2; par_en = 1'b0;
    pulse_rd_clr(1'b1, 1'b1);
    send(9'h0AA, 9, 1'b0);
    check("R6 frm at irq", frm_at_irq, 0);
    check("R6 frm later", int'(ferr), 1);

    // R7: overrun keeps the older word
    fmt = 2'd1;
    pulse_rd_clr(1'b1, 1'b1);
    send(9'h03C, 8, 1'b1);
    send(9'h0C3, 8, 1'b1);
    check("R5 irq on overrun frame", irq_at, 155);
    check("R7 word kept", int'(data), 'h3C);
    check("R7 ovr set", int'(ovr), 1);
    // R8: read clears valid
    pulse_rd_clr(1'b1, 1'b0);
    check("R8 rd clears", int'(valid), 0);
    // R9: sticky across a clean frame, then cleared
    send(9'h011, 8, 1'b1);
    check("R9 ovr sticky", int'(ovr), 1);
    check("R8 new word", int'(data), 'h11);
    pulse_rd_clr(1'b0, 1'b1);
    check("R9 clr", int'(ovr), 0);

    // R2: short low glitch is rejected
    pulse_rd_clr(1'b1, 1'b1);
    begin
      int seen = 0;
      @(negedge clk); rxd = 1'b0;
      repeat (4) @(negedge clk);
      rxd = 1'b1;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        if (irq) seen = 1;
      end
      check("R2 no irq", seen, 0);
      check("R2 no word", int'(valid), 0);
      check("R2 no flags", int'({ovr, perr, ferr}), 0);
    end
    send(9'h0E7, 8, 1'b1);
    check("R2 next frame", int'(data), 'hE7);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule